// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is an execution unit for the bit-operation opcode page of an 8-bit processor. It receives the second byte of a two-byte page instruction, the operand byte the sequencer has already fetched, and the current flag byte. It returns the new operand value, a write-enable for that value, the updated flag byte, and the destination register code. Operand fetch and memory writeback stay with the sequencer.

One page byte carries everything the unit needs. The two top bits pick the operation family: rotate/shift, bit test, bit clear or bit set. The middle three bits give either the rotate/shift kind or the bit index. The low three bits name the register operand. A separate mode input turns the unit into the short accumulator rotator, which changes only the carry, H and N flags. All results are registered once, so they appear on the cycle after `in_valid`.

Flag byte layout used on `flags_in` and `flags_out`: S is bit 7, Z is bit 6, H is bit 4, P/V is bit 2, N is bit 1 and C is bit 0. Bits 5 and 3 are always copied from input to output.

Top module: `rsb_unit`

## Requirements
- R1: With `acc_mode` low, `op_byte[7:6]` selects the family: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Bit test gives `wr_en` low and returns the operand unchanged on `result`. Every other family gives `wr_en` high.
- R2: In the rotate/shift family, `op_byte[5:3]` values 0 to 7 select these kinds. 0 rotates left circular. 1 rotates right circular. 2 rotates left through carry. 3 rotates right through carry. 4 shifts left and inserts 0 at bit 0. 5 shifts right and keeps bit 7. 6 shifts left and inserts 1 at bit 0. 7 shifts right and inserts 0 at bit 7.
- R3: After a rotate/shift, S equals result bit 7, Z is 1 when the result is zero, H and N are 0, and P/V is 1 when the result has an even number of ones. C takes the bit moved out, which is operand bit 7 for left kinds and operand bit 0 for right kinds. Flag bits 5 and 3 pass through unchanged.
- R4: Bit test reads bit `op_byte[5:3]` of the operand. Z and P/V are both set to the inverse of that bit. H is 1 and N is 0. S is 1 only when the index is 7 and the bit is 1. C and bits 5 and 3 are unchanged.
- R5: Bit clear writes the operand with bit `op_byte[5:3]` forced to 0. Bit set writes it with that bit forced to 1. Both return `flags_out` equal to `flags_in`.
- R6: With `acc_mode` high, `op_byte[4:3]` selects left circular, right circular, left through carry or right through carry, and the other page bits are ignored. S, Z, P/V and bits 5 and 3 are unchanged. H and N are 0, C takes the bit moved out, and `wr_en` is 1.
- R7: `dst_code` is `op_byte[2:0]` in page mode and 7 (the accumulator) in accumulator mode. `mem_target` is 1 only in page mode with register code 6.
- R8: `out_valid` equals `in_valid` of the previous cycle, and `wr_en` is never high while `out_valid` is low.
- R9: A synchronous active-high `rst` forces `out_valid` and `wr_en` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| acc_mode | input | 1 | Select accumulator rotate behaviour |
| op_byte | input | 8 | Page opcode byte |
| operand | input | 8 | Operand value |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered result present |
| result | output | 8 | New operand value |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 8 | Updated flag byte |
| dst_code | output | 3 | Destination register code |
| mem_target | output | 1 | Destination is the memory operand |

## Verification
A decode fault, such as a wrong field slice or a swapped kind order, shows up one cycle after the request. It appears as a wrong `result` or carry for particular page bytes, so every page byte is swept in both carry states over several operand patterns. A fault in flag merging shows up as a flag that changes when it should hold, or holds when it should change. This is checked bit by bit against an arithmetic model on every vector. Accumulator mode is swept over all operands, so any leak of S, Z or P/V is caught on the first affected value.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int CODE_W = 3;
    localparam int MEM_CODE = 6;
    localparam int ACC_CODE = 7;

    localparam int FS = 7;
    localparam int FZ = 6;
    localparam int FH = 4;
    localparam int FP = 2;
    localparam int FN = 1;
    localparam int FC = 0;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SLL, SH_SRL
    } shk_e;

    typedef struct packed {
        grp_e              grp;
        shk_e              kind;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] code;
        logic              acc;
        logic              mem;
    } op_s;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              cout;
    } shres_s;

    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
    import rsb_pkg::*;
(
    input  logic [DATA_W-1:0] op_byte,
    input  logic              acc_mode,
    output op_s               op
);
    always_comb begin
        op.acc  = acc_mode;
        op.idx  = op_byte[5:3];
        if (acc_mode) begin
            op.grp  = GRP_SHIFT;
            op.kind = shk_e'({1'b0, op_byte[4:3]});
            op.code = CODE_W'(ACC_CODE);
            op.mem  = 1'b0;
        end else begin
            op.grp  = grp_e'(op_byte[7:6]);
            op.kind = shk_e'(op_byte[5:3]);
            op.code = op_byte[2:0];
            op.mem  = (op_byte[2:0] == CODE_W'(MEM_CODE));
        end
    end
endmodule

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
(
    input  shk_e              kind,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output shres_s            res
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        unique case (kind)
            SH_RLC: res = '{data: {din[MSB-1:0], din[MSB]}, cout: din[MSB]};
            SH_RRC: res = '{data: {din[0], din[MSB:1]},     cout: din[0]};
            SH_RL:  res = '{data: {din[MSB-1:0], cin},      cout: din[MSB]};
            SH_RR:  res = '{data: {cin, din[MSB:1]},        cout: din[0]};
            SH_SLA: res = '{data: {din[MSB-1:0], 1'b0},     cout: din[MSB]};
            SH_SRA: res = '{data: {din[MSB], din[MSB:1]},   cout: din[0]};
            SH_SLL: res = '{data: {din[MSB-1:0], 1'b1},     cout: din[MSB]};
            SH_SRL: res = '{data: {1'b0, din[MSB:1]},       cout: din[0]};
            default: res = '{data: din, cout: cin};
        endcase
    end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
(
    input  grp_e              grp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              bit_val
);
    logic [DATA_W-1:0] mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (idx == IDX_W'(i));
    end

    assign bit_val = |(din & mask);

    always_comb begin
        unique case (grp)
            GRP_CLR: dout = din & ~mask;
            GRP_SET: dout = din | mask;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              acc_mode,
    input  logic [DATA_W-1:0] op_byte,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [DATA_W-1:0] flags_out,
    output logic [CODE_W-1:0] dst_code,
    output logic              mem_target
);
    op_s               op;
    shres_s            sh;
    logic [DATA_W-1:0] bo_data;
    logic              bo_bit;
    logic [DATA_W-1:0] nxt_result;
    logic [DATA_W-1:0] nxt_flags;
    logic              nxt_wr;

    rsb_decode u_dec (
        .op_byte  (op_byte),
        .acc_mode (acc_mode),
        .op       (op)
    );

    rsb_shifter u_sh (
        .kind (op.kind),
        .din  (operand),
        .cin  (flags_in[FC]),
        .res  (sh)
    );

    rsb_bitop u_bo (
        .grp     (op.grp),
        .idx     (op.idx),
        .din     (operand),
        .dout    (bo_data),
        .bit_val (bo_bit)
    );

    always_comb begin
        nxt_flags  = flags_in;
        nxt_result = operand;
        nxt_wr     = 1'b1;
        unique case (op.grp)
            GRP_SHIFT: begin
                nxt_result    = sh.data;
                nxt_flags[FH] = 1'b0;
                nxt_flags[FN] = 1'b0;
                nxt_flags[FC] = sh.cout;
                if (!op.acc) begin
                    nxt_flags[FS] = sh.data[DATA_W-1];
                    nxt_flags[FZ] = (sh.data == '0);
                    nxt_flags[FP] = even_par(sh.data);
                end
            end
            GRP_TEST: begin
                nxt_wr        = 1'b0;
                nxt_flags[FZ] = ~bo_bit;
                nxt_flags[FP] = ~bo_bit;
                nxt_flags[FH] = 1'b1;
                nxt_flags[FN] = 1'b0;
                nxt_flags[FS] = bo_bit && (op.idx == IDX_W'(DATA_W-1));
            end
            default: nxt_result = bo_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            wr_en      <= 1'b0;
            result     <= '0;
            flags_out  <= '0;
            dst_code   <= '0;
            mem_target <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && nxt_wr;
            if (in_valid) begin
                result     <= nxt_result;
                flags_out  <= nxt_flags;
                dst_code   <= op.code;
                mem_target <= op.mem;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_en));
    // R3
    shift_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !acc_mode && op_byte[7:6] == 2'b00) |=>
        (!flags_out[FH] && !flags_out[FN] && flags_out[FZ] == (result == '0)
         && flags_out[FS] == result[DATA_W-1]));
    // R4
    test_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !acc_mode && op_byte[7:6] == 2'b01) |=>
        (!wr_en && flags_out[FH] && !flags_out[FN]
         && flags_out[FC] == $past(flags_in[FC])));
    // R5
    setclr_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !acc_mode && op_byte[7]) |=>
        (wr_en && flags_out == $past(flags_in)));
    // R6
    acc_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_mode) |=>
        (wr_en && !flags_out[FH] && !flags_out[FN]
         && flags_out[FS] == $past(flags_in[FS])
         && flags_out[FZ] == $past(flags_in[FZ])
         && flags_out[FP] == $past(flags_in[FP])
         && dst_code == CODE_W'(ACC_CODE)));
endmodule

// File: tb/tb_rsb_unit.sv
module tb_rsb_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       acc_mode;
    logic [7:0] op_byte;
    logic [7:0] operand;
    logic [7:0] flags_in;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en;
    logic [7:0] flags_out;
    logic [2:0] dst_code;
    logic       mem_target;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_mode(acc_mode),
        .op_byte(op_byte), .operand(operand), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .flags_out(flags_out), .dst_code(dst_code), .mem_target(mem_target)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (op=%02h acc=%0b opnd=%02h f=%02h)",
                     req, act, exp, op_byte, acc_mode, operand, flags_in);
        end
    endtask

    task automatic shift_model(input int k, input int v, input int c,
                               output int r, output int co);
        case (k)
            0: begin r = (v*2)%256 + v/128; co = v/128; end
            1: begin r = v/2 + (v%2)*128;   co = v%2;   end
            2: begin r = (v*2)%256 + c;     co = v/128; end
            3: begin r = v/2 + c*128;       co = v%2;   end
            4: begin r = (v*2)%256;         co = v/128; end
            5: begin r = v/2 + (v/128)*128; co = v%2;   end
            6: begin r = (v*2)%256 + 1;     co = v/128; end
            default: begin r = v/2;         co = v%2;   end
        endcase
    endtask

    task automatic run_vec(input bit acc, input int p, input int v, input int fi);
        int r, co, f, we, dc, mt, grp, b, bitv, ones;
        string tag_r, tag_f;
        in_valid = 1'b1;
        acc_mode = acc;
        op_byte  = 8'(p);
        operand  = 8'(v);
        flags_in = 8'(fi);
        f  = fi;
        r  = v;
        we = 1;
        dc = acc ? 7 : p % 8;
        mt = (!acc && (p % 8) == 6) ? 1 : 0;
        grp = p / 64;
        b  = (p / 8) % 8;
        if (acc) begin
            shift_model((p / 8) % 4, v, fi % 2, r, co);
            f = (f & ~8'h13) | co;
            tag_r = "R6"; tag_f = "R6";
        end else if (grp == 0) begin
            shift_model(b, v, fi % 2, r, co);
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            f = (fi & 8'h28) | ((r / 128) * 128) | ((r == 0) ? 64 : 0)
                | ((ones % 2 == 0) ? 4 : 0) | co;
            tag_r = "R2"; tag_f = "R3";
        end else if (grp == 1) begin
            bitv = (v >> b) & 1;
            we = 0;
            f = (fi & 8'h29) | 16 | ((bitv == 0) ? 64 + 4 : 0)
                | ((b == 7 && bitv == 1) ? 128 : 0);
            tag_r = "R1"; tag_f = "R4";
        end else begin
            r = (grp == 2) ? (v & ~(1 << b) & 255) : (v | (1 << b));
            tag_r = "R5"; tag_f = "R5";
        end
        @(negedge clk);
        chk("R8 valid", out_valid, 1);
        chk(tag_r, result, r);
        chk("R1 wr_en", wr_en, we);
        chk(tag_f, flags_out, f);
        chk("R7 dst", {dst_code, mem_target}, dc*2 + mt);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; acc_mode = 1'b0;
        op_byte = '0; operand = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", out_valid, 0);
        chk("R9 wr_en", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 idle", out_valid, 0);

        for (int p = 0; p < 256; p++) begin
            for (int oi = 0; oi < 8; oi++) begin
                for (int c = 0; c < 2; c++) begin
                    int v;
                    case (oi)
                        0: v = 8'h00; 1: v = 8'h01; 2: v = 8'h80; 3: v = 8'hFF;
                        4: v = 8'h55; 5: v = 8'hAA; 6: v = 8'h3C; default: v = 8'hC3;
                    endcase
                    run_vec(1'b0, p, v, (((oi*37 + p*11) & 8'hFE) | c));
                end
            end
        end

        // R6 accumulator rotates, with junk in the ignored page bits
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 256; v++) begin
                for (int c = 0; c < 2; c++) begin
                    run_vec(1'b1, ((v*13) & 8'hE7) | (k*8), v, ((v*29 + k) & 8'hFE) | c);
                end
            end
        end

        // R8 idle cycle after traffic
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 drop valid", out_valid, 0);
        chk("R8 drop wr_en", wr_en, 0);

        // R9 reset during traffic
        run_vec(1'b0, 8'hC6, 8'h00, 8'h00);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9 mid reset valid", out_valid, 0);
        chk("R9 mid reset wr_en", wr_en, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule